// File: doc/BRIEF.md
# Byte-Wide SAR Converter Read Sequencer

This block sits on the host side of a 16-bit successive-approximation converter. The converter returns its result over an 8-bit tri-state bus. The controller drives three control lines. The first is an active-low chip-select. The second is a read/convert select, where low means convert and high means read. The third is a byte select, where 1 puts the upper byte on the bus and 0 puts the lower byte. One pulse on `start` runs a full sequence of three chip-select falling edges:

- The first edge, with read/convert low, wakes the converter and starts tracking.
- The second edge, also with read/convert low, freezes the sample and starts conversion.
- The third edge, with read/convert high, reads the result.

The block waits a programmable conversion time before the read. It captures the upper byte and then the lower byte, each after a programmable settle delay. It then raises chip-select and presents the 16-bit word.

A period counter paces the first edges of successive sequences. The pacing interval is the larger of a programmable value and the minimum that a 135k samples-per-second converter allows at the given clock frequency. The converter codes its output in offset binary. The block inverts bit 15, so the result word is two's complement.

The result leaves through `res_valid`/`res_data` as a one-cycle pulse with no back-pressure. The consumer must take the word in the cycle `res_valid` is high, because there is no ready input and the word is not held for a later cycle.

Configuration inputs must stay constant while `busy` is high. A change of configuration is applied together with a reset. The reset is synchronous and active high.

Top module: `adc_rd_seq`

## Requirements
- R1: In the cycle after synchronous reset is released, `cs_n`=1, `rd_conv`=0, `hben`=0, `res_valid`=0, `busy`=0 and `overrun`=0.
- R2: Each accepted start produces exactly three `cs_n` falling edges. The first and second occur with `rd_conv`=0. The third occurs with `rd_conv`=1.
- R3: Between any two successive `cs_n` falling edges, `cs_n` stays high for at least max(`cfg_cs_high`,1) cycles.
- R4: The third falling edge comes at least `cfg_conv` cycles after the second.
- R5: At the third falling edge `hben`=1. The upper byte (result bits 15:8) is taken from `bus_d` while `hben`=1. `hben` then goes to 0 with `cs_n` still low, and the lower byte (bits 7:0) is taken from the bus. Each byte is taken after max(`cfg_settle`,1) cycles.
- R6: `res_data` equals {upper byte, lower byte} with bit 15 inverted, which converts offset binary to two's complement. `res_valid` is high for exactly one cycle per accepted start.
- R7: A `start` that arrives while `busy`=1 is ignored, so it produces no extra edges or result. It sets `overrun`, which then stays 1 until reset.
- R8: The first falling edges of two successive sequences are at least P cycles apart, where P = max(`cfg_period`, ceil(CLK_HZ/135000)). When the next start arrives before that interval ends, they are exactly P cycles apart.
- R9: In the cycle `res_valid` is 1, `cs_n` is already high and `rd_conv` and `hben` are both back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one conversion sequence |
| cfg_settle | input | CW | Chip-select low time and bus settle delay, in cycles |
| cfg_cs_high | input | CW | Minimum chip-select high time between falling edges |
| cfg_conv | input | CW | Conversion wait after the second falling edge |
| cfg_period | input | CW | Requested sample period in cycles (clamped to the rate limit) |
| bus_d | input | BW | Converter data bus |
| cs_n | output | 1 | Active-low chip-select |
| rd_conv | output | 1 | 1 = read, 0 = convert/acquire |
| hben | output | 1 | Byte select: 1 upper byte, 0 lower byte |
| res_data | output | 2*BW | Two's complement result |
| res_valid | output | 1 | One-cycle result strobe, no back-pressure |
| busy | output | 1 | Sequence in progress |
| overrun | output | 1 | Sticky: start seen while busy |

## Verification
The hardest state to reach from the ports is a start request that lands while a sequence is already running. The stimulus reaches it by waiting a few cycles into a sequence and pulsing `start` again. The bench then checks that no fourth edge and no second result appear, and that `overrun` stays set through a later clean sequence. Exact pacing is the other delicate case. It is reached by issuing each start as soon as `busy` drops, well before the pacing interval has run out. With this stimulus the first-edge spacing must equal the clamped period in one configuration, where the rate limit dominates, and the requested period in another. A second configuration also makes the conversion wait shorter than the chip-select high minimum, so the longer of the two must govern the read edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PACE,
    S_WAKE,
    S_GAP,
    S_SAMP,
    S_CONV,
    S_RSET,
    S_RHI,
    S_RLO,
    S_DONE
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic rd_conv;
    logic hben;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_REST = '{cs_n: 1'b1, rd_conv: 1'b0, hben: 1'b0};

  // Control-line levels wanted while the sequencer sits in a given state.
  function automatic bus_ctl_t ctl_for(input seq_st_e s);
    bus_ctl_t c;
    c = CTL_REST;
    case (s)
      S_WAKE, S_SAMP: c.cs_n = 1'b0;
      S_RSET: begin
        c.rd_conv = 1'b1;
        c.hben    = 1'b1;
      end
      S_RHI: begin
        c.cs_n    = 1'b0;
        c.rd_conv = 1'b1;
        c.hben    = 1'b1;
      end
      S_RLO: begin
        c.cs_n    = 1'b0;
        c.rd_conv = 1'b1;
      end
      default: c = CTL_REST;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/seq_downcnt.sv
module seq_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rate_pacer.sv
module rate_pacer #(
  parameter int W     = 16,
  parameter int MIN_P = 741
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mark,
  input  logic [W-1:0] cfg_period,
  output logic         ready
);
  localparam logic [W-1:0] MIN_V = W'(MIN_P);

  logic [W-1:0] eff;
  logic [W-1:0] reload;

  always_comb begin
    eff    = (cfg_period < MIN_V) ? MIN_V : cfg_period;
    reload = (eff == '0) ? '0 : eff - 1'b1;
  end

  seq_downcnt #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (mark),
    .load_val (reload),
    .zero     (ready)
  );
endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int BW        = 8,
  parameter bit OFFSET_IN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] bus_d,
  input  logic          take_hi,
  input  logic          take_lo,
  output logic [2*BW-1:0] word,
  output logic          valid
);
  localparam int DW = 2 * BW;

  logic [BW-1:0] hi_q;
  logic [DW-1:0] flip;

  generate
    if (OFFSET_IN) begin : g_offset
      assign flip = {1'b1, {(DW-1){1'b0}}};
    end else begin : g_twos
      assign flip = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (take_hi) hi_q <= bus_d;
      if (take_lo) begin
        word  <= {hi_q, bus_d} ^ flip;
        valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_settle,
  input  logic [CW-1:0] cfg_cs_high,
  input  logic [CW-1:0] cfg_conv,
  input  logic          pace_ready,
  output logic          mark,
  output logic          take_hi,
  output logic          take_lo,
  output bus_ctl_t      ctl,
  output logic          busy,
  output logic          overrun
);
  seq_st_e       st_q, st_d;
  logic          t_zero;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic [CW-1:0] conv_span;

  function automatic logic [CW-1:0] less_one(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign conv_span = (cfg_conv > cfg_cs_high) ? cfg_conv : cfg_cs_high;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start)      st_d = S_PACE;
      S_PACE: if (pace_ready) st_d = S_WAKE;
      S_WAKE: if (t_zero)     st_d = S_GAP;
      S_GAP:  if (t_zero)     st_d = S_SAMP;
      S_SAMP: if (t_zero)     st_d = S_CONV;
      S_CONV: if (t_zero)     st_d = S_RSET;
      S_RSET:                 st_d = S_RHI;
      S_RHI:  if (t_zero)     st_d = S_RLO;
      S_RLO:  if (t_zero)     st_d = S_DONE;
      S_DONE: if (t_zero)     st_d = S_IDLE;
      default:                st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      S_WAKE, S_SAMP, S_RHI, S_RLO: t_val = less_one(cfg_settle);
      S_GAP, S_DONE:                t_val = less_one(cfg_cs_high);
      S_CONV:                       t_val = less_one(conv_span);
      default:                      t_val = '0;
    endcase
  end

  assign t_load = (st_d != st_q);

  seq_downcnt #(.W(CW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      ctl     <= CTL_REST;
      overrun <= 1'b0;
    end else begin
      st_q <= st_d;
      ctl  <= ctl_for(st_d);
      if (start && (st_q != S_IDLE)) overrun <= 1'b1;
    end
  end

  assign mark    = (st_d == S_WAKE) && (st_q != S_WAKE);
  assign take_hi = (st_q == S_RHI) && t_zero;
  assign take_lo = (st_q == S_RLO) && t_zero;
  assign busy    = (st_q != S_IDLE);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int MAX_RATE  = 135_000,
  parameter int CW        = 16,
  parameter int BW        = 8,
  parameter bit OFFSET_IN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW-1:0]   cfg_settle,
  input  logic [CW-1:0]   cfg_cs_high,
  input  logic [CW-1:0]   cfg_conv,
  input  logic [CW-1:0]   cfg_period,
  input  logic [BW-1:0]   bus_d,
  output logic            cs_n,
  output logic            rd_conv,
  output logic            hben,
  output logic [2*BW-1:0] res_data,
  output logic            res_valid,
  output logic            busy,
  output logic            overrun
);
  localparam int MIN_PERIOD = (CLK_HZ + MAX_RATE - 1) / MAX_RATE;

  logic     mark, pace_ready, take_hi, take_lo;
  bus_ctl_t ctl;

  rate_pacer #(.W(CW), .MIN_P(MIN_PERIOD)) u_pace (
    .clk        (clk),
    .rst        (rst),
    .mark       (mark),
    .cfg_period (cfg_period),
    .ready      (pace_ready)
  );

  seq_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cfg_settle  (cfg_settle),
    .cfg_cs_high (cfg_cs_high),
    .cfg_conv    (cfg_conv),
    .pace_ready  (pace_ready),
    .mark        (mark),
    .take_hi     (take_hi),
    .take_lo     (take_lo),
    .ctl         (ctl),
    .busy        (busy),
    .overrun     (overrun)
  );

  word_assembler #(.BW(BW), .OFFSET_IN(OFFSET_IN)) u_word (
    .clk     (clk),
    .rst     (rst),
    .bus_d   (bus_d),
    .take_hi (take_hi),
    .take_lo (take_lo),
    .word    (res_data),
    .valid   (res_valid)
  );

  assign cs_n    = ctl.cs_n;
  assign rd_conv = ctl.rd_conv;
  assign hben    = ctl.hben;
endmodule

// File: rtl/adc_rd_seq_chk.sv
module adc_rd_seq_chk #(
  parameter int CW         = 16,
  parameter int MIN_PERIOD = 741
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] cfg_cs_high,
  input logic [CW-1:0] cfg_conv,
  input logic [CW-1:0] cfg_period,
  input logic          cs_n,
  input logic          rd_conv,
  input logic          hben,
  input logic          res_valid,
  input logic          busy,
  input logic          overrun
);
  logic        cs_prev, fall, seen_fall, seen_first;
  logic [1:0]  nfall;
  logic [31:0] high_run, since_samp, since_first;
  logic [31:0] hmin_eff, per_eff;

  assign fall     = cs_prev && !cs_n;
  assign hmin_eff = (cfg_cs_high == '0) ? 32'd1 : 32'(cfg_cs_high);
  assign per_eff  = (32'(cfg_period) < 32'(MIN_PERIOD)) ? 32'(MIN_PERIOD) : 32'(cfg_period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev     <= 1'b1;
      nfall       <= 2'd0;
      seen_fall   <= 1'b0;
      seen_first  <= 1'b0;
      high_run    <= '0;
      since_samp  <= '0;
      since_first <= '0;
    end else begin
      cs_prev  <= cs_n;
      high_run <= !cs_n ? 32'd0 : (high_run == '1 ? high_run : high_run + 1);
      since_samp  <= (since_samp  == '1) ? since_samp  : since_samp + 1;
      since_first <= (since_first == '1) ? since_first : since_first + 1;
      if (fall) begin
        seen_fall <= 1'b1;
        nfall     <= (nfall == 2'd2) ? 2'd0 : nfall + 1'b1;
        if (nfall == 2'd0) begin
          since_first <= 32'd1;
          seen_first  <= 1'b1;
        end
        if (nfall == 2'd1) since_samp <= 32'd1;
      end
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n && !rd_conv && !hben && !res_valid && !busy && !overrun));

  p_convert_edges_r2: assert property (@(posedge clk) disable iff (rst)
    (fall && nfall != 2'd2) |-> !rd_conv);

  p_read_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (fall && nfall == 2'd2) |-> (rd_conv && hben));

  p_cs_high_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (fall && seen_fall) |-> (high_run >= hmin_eff));

  p_conv_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (fall && nfall == 2'd2) |-> (since_samp >= 32'(cfg_conv)));

  p_hben_in_read_r5: assert property (@(posedge clk) disable iff (rst)
    hben |-> rd_conv);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> overrun);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_pace_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    (fall && nfall == 2'd0 && seen_first) |-> (since_first >= per_eff));

  p_release_on_valid_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cs_n && !rd_conv && !hben));
endmodule

bind adc_rd_seq adc_rd_seq_chk #(.CW(CW), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .cfg_cs_high (cfg_cs_high),
  .cfg_conv    (cfg_conv),
  .cfg_period  (cfg_period),
  .cs_n        (cs_n),
  .rd_conv     (rd_conv),
  .hben        (hben),
  .res_valid   (res_valid),
  .busy        (busy),
  .overrun     (overrun)
);

// File: tb/sim_adc_rd_seq.sv
module sim_adc_rd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cfg_settle = 16'd3, cfg_cs_high = 16'd4, cfg_conv = 16'd20, cfg_period = 16'd0;
  wire  [7:0]  bus_d;
  logic        cs_n, rd_conv, hben, res_valid, busy, overrun;
  logic [15:0] res_data;

  always #5 clk = ~clk;

  adc_rd_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_settle(cfg_settle), .cfg_cs_high(cfg_cs_high),
    .cfg_conv(cfg_conv), .cfg_period(cfg_period),
    .bus_d(bus_d), .cs_n(cs_n), .rd_conv(rd_conv), .hben(hben),
    .res_data(res_data), .res_valid(res_valid), .busy(busy), .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;
  int exp_period = 741;
  logic [15:0] exp_q[$];
  logic [15:0] analog = 16'h0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural converter stub: counts chip-select falls, freezes the
  // sample on the second one, drives the offset-binary word on the read.
  int   nfall, t_first, t_samp, high_run;
  bit   have_first, seen_fall, rd_active, cs_prev;
  logic [15:0] sample;

  assign bus_d = (rd_active && !cs_n) ? (hben ? sample[15:8] : sample[7:0]) : 8'hzz;

  always @(negedge clk) begin
    if (rst) begin
      nfall = 0; have_first = 0; seen_fall = 0; rd_active = 0;
      cs_prev = 1; high_run = 0; sample = '0; t_first = 0; t_samp = 0;
    end else begin
      if (cs_prev && !cs_n) begin
        if (seen_fall)
          check(high_run >= ((cfg_cs_high == 0) ? 1 : int'(cfg_cs_high)), "R3",
                "cs_n high run", high_run, cfg_cs_high);
        seen_fall = 1;
        case (nfall)
          0: begin
            check(!rd_conv, "R2", "rd_conv at wake edge", rd_conv, 0);
            if (have_first)
              check(cyc - t_first == exp_period, "R8", "first-edge spacing",
                    cyc - t_first, exp_period);
            t_first = cyc; have_first = 1; nfall = 1;
          end
          1: begin
            check(!rd_conv, "R2", "rd_conv at sample edge", rd_conv, 0);
            sample = analog ^ 16'h8000;
            t_samp = cyc; nfall = 2;
          end
          default: begin
            check(rd_conv, "R2", "rd_conv at read edge", rd_conv, 1);
            check(hben, "R5", "hben at read edge", hben, 1);
            check(cyc - t_samp >= int'(cfg_conv), "R4", "conversion wait",
                  cyc - t_samp, cfg_conv);
            rd_active = 1; nfall = 0;
          end
        endcase
      end
      if (cs_n) begin
        rd_active = 0;
        high_run = high_run + 1;
      end else begin
        high_run = 0;
      end
      cs_prev = cs_n;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "result with no pending start", res_data, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(res_data == e, "R6", "result word", res_data, e);
      end
      check(cs_n && !rd_conv && !hben, "R9", "lines released with valid",
            {cs_n, rd_conv, hben}, 3'b100);
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_seq(input logic [15:0] v);
    while (busy) @(negedge clk);
    analog = v;
    exp_q.push_back(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !rd_conv && !hben, "R1", "control lines after reset",
          {cs_n, rd_conv, hben}, 3'b100);
    check(!busy && !res_valid, "R1", "busy/valid after reset", {busy, res_valid}, 0);
    check(!overrun, "R1", "overrun after reset", overrun, 0);
  endtask

  initial begin
    // Configuration A: rate limit dominates the requested period
    do_reset();
    run_seq(16'h0000);
    run_seq(16'h7FFF);
    run_seq(16'h8000);
    run_seq(16'hFFFF);
    run_seq(16'h1234);
    run_seq(16'hA5C3);
    wait_idle();
    check(exp_q.size() == 0, "R6", "all results delivered", exp_q.size(), 0);

    // Start while busy: ignored, sticky overrun
    run_seq(16'h5A01);
    repeat (5) @(negedge clk);
    check(!overrun && busy, "R7", "no overrun before extra start", overrun, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(overrun, "R7", "overrun after start while busy", overrun, 1);
    check(exp_q.size() == 0, "R7", "extra start produced no result", exp_q.size(), 0);
    run_seq(16'h3C3C);
    wait_idle();
    check(overrun, "R7", "overrun still set", overrun, 1);
    check(exp_q.size() == 0, "R7", "single result after overrun", exp_q.size(), 0);

    // Configuration B: long requested period, conversion shorter than cs gap
    cfg_settle = 16'd1; cfg_cs_high = 16'd6; cfg_conv = 16'd2; cfg_period = 16'd1000;
    exp_period = 1000;
    do_reset();
    run_seq(16'h0001);
    run_seq(16'hFFFE);
    run_seq(16'h4321);
    wait_idle();
    check(exp_q.size() == 0, "R6", "all results delivered B", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule